// File: doc/BRIEF.md
# Microprogrammed Control Sequencer with Mode-Bit Address Modification

This block is a small microprogrammed control unit with a register-level datapath model attached. A micro-program counter selects a word from an on-chip constant control store. Each word holds bus gating strobes and a next-address selector. The unit fetches an instruction through an external memory handshake and dispatches on its opcode. It then runs the matching microroutine: an add whose source operand may be a register, an autoincremented pointer or an autoincremented pointer to a pointer, or a relative branch taken when the negative flag is set.

Microbranch targets are not stored whole. At the dispatch word the decoder supplies a base address, and selected micro-PC bits are then set from the instruction's mode bits. A later word ORs one mode bit into bit 0 of a jump target, which skips an indirection step. Memory reads are requested with a one-cycle strobe. Any word that waits for memory holds the micro-PC until the completion input has been seen. Register-file writes are visible on a write port, so an integrator or a bench can follow execution.

Top module: `useq_ctrl`

## Requirements
- R1: While rst_n is low, upc_o and pc_o are 0 and mem_rd, end_o and rf_we are 0. After reset, register Ri holds i shifted left by DW/2.
- R2: Micro-words 0 to 2 fetch an instruction. mem_rd pulses with mem_addr equal to the PC, the PC advances by STEP, and the returned word is loaded into the instruction register.
- R3: At micro-address 3, opcode (IR[15:11]) 5'b00001 dispatches to octal 101 with micro-PC bit 5 set to IR[10], bit 4 set to IR[9] and bit 3 set to (not IR[10]) and (not IR[9]) and IR[8]. Opcode 5'b00010 dispatches to octal 040. Any other opcode returns to address 0 with no End and no register write.
- R4: At octal 040, cond_n low sends the micro-PC to 0. cond_n high adds the sign-extended IR[7:0] to the already advanced PC and asserts End.
- R5: Add with mode IR[10:8]=3'b011 reads memory at Rsrc, writes Rsrc+STEP back into Rsrc, adds the read word to Rdst (IR[3:0]), and never visits octal 170.
- R6: Add with mode 3'b010 also increments Rsrc. It visits octal 170 to read a second time at the address returned by the first read, and adds that second word to Rdst.
- R7: Add with mode 3'b000 writes Rdst + Rsrc (Rsrc = IR[7:4]) into Rdst without a data read.
- R8: Add with mode 001, 100, 101, 110 or 111 ends the instruction without any register write or data read.
- R9: A word that waits for memory holds the micro-PC until mem_mfc has been seen for its read. With a response latency of L cycles, the fetch wait word occupies L+1 cycles. mem_rd is never high two cycles in a row.
- R10: The cycle after end_o is high, upc_o is 0.
- R11: Each register write appears on rf_we/rf_waddr/rf_wdata in the cycle it is made, with the exact count, order, index and value the instruction implies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_n | input | 1 | Negative condition flag tested by the branch routine |
| mem_mfc | input | 1 | One-cycle memory completion strobe carrying mem_rdata |
| mem_rdata | input | DW | Read data, valid with mem_mfc |
| mem_rd | output | 1 | One-cycle read request |
| mem_addr | output | DW | Memory address register contents |
| upc_o | output | UW | Current micro-program counter |
| end_o | output | 1 | High while the final word of an instruction executes |
| pc_o | output | DW | Program counter |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 4 | Index of the register being written |
| rf_wdata | output | DW | Value being written |

## Verification
The bench builds the block with DW=16, STEP=4 and UW=7. This gives the 16-bit instruction layout the dispatch logic decodes and the full octal address range up to 173. With 16-bit registers, repeated additions of scrambled memory words wrap around, so carries out of the top bit are exercised. Random memory latencies of one to four cycles cover responses that arrive both before and after a wait word is reached. Fixed latencies of 1 and 6 pin down the exact stall length.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int DW   = 16,
  parameter int STEP = 4,
  parameter int UW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cond_n,
  input  logic          mem_mfc,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic [DW-1:0] mem_addr,
  output logic [UW-1:0] upc_o,
  output logic          end_o,
  output logic [DW-1:0] pc_o,
  output logic          rf_we,
  output logic [3:0]    rf_waddr,
  output logic [DW-1:0] rf_wdata
);
  localparam int NREG = 16;
  localparam int FW   = 11;
  localparam int CW   = UW + 3 + FW + 3;

  localparam logic [2:0] S_NONE = 3'd0, S_PC = 3'd1, S_MDR = 3'd2, S_Z = 3'd3,
                         S_RS = 3'd4, S_RD = 3'd5, S_OFF = 3'd6;
  localparam logic [FW-1:0] F_PCIN = 11'h001, F_MARIN = 11'h002, F_IRIN = 11'h004,
                            F_YIN  = 11'h008, F_ZIN   = 11'h010, F_SEL4 = 11'h020,
                            F_RSIN = 11'h040, F_RDIN  = 11'h080, F_RD   = 11'h100,
                            F_WMFC = 11'h200, F_END   = 11'h400;
  localparam logic [2:0] N_SEQ = 3'd0, N_DISP = 3'd1, N_BRN0 = 3'd2, N_JMP = 3'd3, N_JOR8 = 3'd4;
  localparam logic [4:0] OP_ADD = 5'd1, OP_BRN = 5'd2;

  function automatic logic [CW-1:0] mk(input logic [2:0] s, input logic [FW-1:0] f,
                                       input logic [2:0] n, input int a);
    return {UW'(a), n, f, s};
  endfunction

  function automatic logic [CW-1:0] store(input logic [UW-1:0] a);
    case (int'(a))
      'o000: return mk(S_PC,   F_MARIN | F_RD | F_SEL4 | F_ZIN, N_SEQ, 0);
      'o001: return mk(S_Z,    F_PCIN | F_YIN | F_WMFC, N_SEQ, 0);
      'o002: return mk(S_MDR,  F_IRIN, N_SEQ, 0);
      'o003: return mk(S_NONE, '0, N_DISP, 0);
      'o040: return mk(S_NONE, '0, N_BRN0, 'o000);
      'o041: return mk(S_OFF,  F_ZIN, N_SEQ, 0);
      'o042: return mk(S_Z,    F_PCIN | F_END, N_SEQ, 0);
      'o101: return mk(S_RS,   F_YIN, N_JMP, 'o172);
      'o121: return mk(S_RS,   F_MARIN | F_RD | F_SEL4 | F_ZIN, N_SEQ, 0);
      'o122: return mk(S_Z,    F_RSIN, N_SEQ, 0);
      'o123: return mk(S_NONE, F_WMFC, N_JOR8, 'o170);
      'o170: return mk(S_MDR,  F_MARIN | F_RD | F_WMFC, N_SEQ, 0);
      'o171: return mk(S_MDR,  F_YIN, N_SEQ, 0);
      'o172: return mk(S_RD,   F_ZIN, N_SEQ, 0);
      'o173: return mk(S_Z,    F_RDIN | F_END, N_SEQ, 0);
      default: return mk(S_NONE, F_END, N_SEQ, 0);
    endcase
  endfunction

  logic [UW-1:0] upc_q, disp, nxt;
  logic          hold_q, flag_q, rd_q;
  logic [DW-1:0] pc_q, mar_q, ir_q, y_q, z_q, mdr_q, bus, alu;
  logic [DW-1:0] regs [NREG];

  logic [CW-1:0] cw;
  logic [FW-1:0] fl;
  logic [2:0]    src, nsel;
  logic [UW-1:0] tgt;
  logic          exec, ready, done;

  assign cw   = store(upc_q);
  assign src  = cw[2:0];
  assign fl   = cw[3+FW-1:3];
  assign nsel = cw[3+FW+2:3+FW];
  assign tgt  = cw[CW-1:CW-UW];

  assign exec  = !hold_q;
  assign ready = flag_q | mem_mfc;
  assign done  = !fl[9] || (ready && !(exec && fl[8]));

  always_comb begin
    case (src)
      S_PC:    bus = pc_q;
      S_MDR:   bus = mdr_q;
      S_Z:     bus = z_q;
      S_RS:    bus = regs[ir_q[7:4]];
      S_RD:    bus = regs[ir_q[3:0]];
      S_OFF:   bus = {{(DW-8){ir_q[7]}}, ir_q[7:0]};
      default: bus = '0;
    endcase
  end

  assign alu = (fl[5] ? DW'(STEP) : y_q) + bus;

  always_comb begin
    case (ir_q[15:11])
      OP_ADD:  disp = UW'('o101) | UW'({ir_q[10], ir_q[9], ~ir_q[10] & ~ir_q[9] & ir_q[8], 3'b000});
      OP_BRN:  disp = UW'('o040);
      default: disp = '0;
    endcase
  end

  always_comb begin
    case (nsel)
      N_DISP:  nxt = disp;
      N_BRN0:  nxt = cond_n ? upc_q + 1'b1 : tgt;
      N_JMP:   nxt = tgt;
      N_JOR8:  nxt = tgt | UW'(ir_q[8]);
      default: nxt = upc_q + 1'b1;
    endcase
  end

  assign rf_we    = exec && (fl[6] || fl[7]);
  assign rf_waddr = fl[6] ? ir_q[7:4] : ir_q[3:0];
  assign rf_wdata = bus;
  assign end_o    = exec && fl[10];
  assign upc_o    = upc_q;
  assign pc_o     = pc_q;
  assign mem_addr = mar_q;
  assign mem_rd   = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q <= '0; hold_q <= 1'b0; flag_q <= 1'b0; rd_q <= 1'b0;
      pc_q <= '0; mar_q <= '0; ir_q <= '0; y_q <= '0; z_q <= '0; mdr_q <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= DW'(i) << (DW / 2);
    end else begin
      if (done) upc_q <= fl[10] ? '0 : nxt;
      hold_q <= !done;
      rd_q   <= exec && fl[8];
      if (exec && fl[8]) flag_q <= 1'b0;
      else if (mem_mfc)  flag_q <= 1'b1;
      if (mem_mfc) mdr_q <= mem_rdata;
      if (exec) begin
        if (fl[0]) pc_q  <= bus;
        if (fl[1]) mar_q <= bus;
        if (fl[2]) ir_q  <= bus;
        if (fl[3]) y_q   <= bus;
        if (fl[4]) z_q   <= alu;
        if (rf_we) regs[rf_waddr] <= bus;
      end
    end
  end

  a_r10_end_clears_upc: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |=> (upc_o == '0));
  a_r9_wait_holds_upc: assert property (@(posedge clk) disable iff (!rst_n)
    (fl[9] && !done) |=> $stable(upc_o));
  a_r9_read_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  a_r2_fetch_address: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_o == '0 && exec) |=> (mem_rd && mem_addr == $past(pc_q)));
  a_r3_add_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_o == UW'('o003) && ir_q[15:11] == OP_ADD) |=> (upc_o[6] && upc_o[2:0] == 3'b001));
  a_r4_no_branch_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_o == UW'('o040) && !cond_n) |=> (upc_o == '0));
  a_r5_skip_indirect: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_o == UW'('o123) && ir_q[8] && done) |=> (upc_o == UW'('o171)));
endmodule

// File: tb/useq_ctrl_bench.sv
module useq_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cond_n = 1'b0, mem_mfc = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic mem_rd, end_o, rf_we;
  logic [15:0] mem_addr, pc_o, rf_wdata;
  logic [6:0] upc_o;
  logic [3:0] rf_waddr;

  useq_ctrl u_useq_ctrl (.clk(clk), .rst_n(rst_n), .cond_n(cond_n), .mem_mfc(mem_mfc),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr), .upc_o(upc_o),
    .end_o(end_o), .pc_o(pc_o), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata));

  int checks = 0, fails = 0, cnt = 0, fix_lat = 0, nreads = 0, wd = 0;
  logic [15:0] cur_instr = '0, resp = '0, last_fetch = '0, mpc;
  logic [15:0] mr [16];

  function automatic logic [15:0] data_fn(input logic [15:0] a);
    return {a[6:0], a[15:7]} ^ 16'h5A3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_mfc = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin mem_mfc = 1'b1; mem_rdata = resp; end
    end
    if (rst_n && mem_rd) begin
      cnt = (fix_lat > 0) ? fix_lat : 1 + int'($urandom % 4);
      if (upc_o == 7'o001) begin resp = cur_instr; last_fetch = mem_addr; end
      else resp = data_fn(mem_addr);
      nreads++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_instr(input logic [15:0] ins, input logic n, input string tg);
    logic [4:0] op = ins[15:11];
    logic [2:0] md = ins[10:8];
    logic [3:0] s = ins[7:4], d = ins[3:0];
    logic [15:0] a, v, fexp;
    logic [3:0] ei [2];
    logic [15:0] ed [2];
    logic [3:0] gi [4];
    logic [15:0] gd [4];
    logic [127:0] vis = '0;
    logic [6:0] tgt;
    int en = 0, gn = 0, ends = 0, eends = 0, ereads = 1, c1 = 0;
    bit left = 0, pend = 0, fin = 0;
    fexp = mpc;
    mpc = mpc + 16'd4;
    tgt = 7'o101 | {1'b0, md[2], md[1], ~md[2] & ~md[1] & md[0], 3'b000};
    if (op == 5'd1) begin
      eends = 1;
      if (md == 3'b000) begin
        mr[d] = mr[d] + mr[s]; ei[0] = d; ed[0] = mr[d]; en = 1;
      end else if (md == 3'b011 || md == 3'b010) begin
        a = mr[s]; mr[s] = a + 16'd4; ei[0] = s; ed[0] = mr[s];
        v = (md == 3'b011) ? data_fn(a) : data_fn(data_fn(a));
        ereads = (md == 3'b011) ? 2 : 3;
        mr[d] = mr[d] + v; ei[1] = d; ed[1] = mr[d]; en = 2;
      end
    end else if (op == 5'd2 && n) begin
      mpc = mpc + {{8{ins[7]}}, ins[7:0]}; eends = 1;
    end
    cur_instr = ins; cond_n = n; nreads = 0;
    for (int c = 0; c < 2000; c++) begin
      if (c > 0) @(negedge clk);
      if (pend) chk({tg, " R10 upc after end"}, upc_o, 0);
      if (upc_o != 0) left = 1;
      else if (left) begin fin = 1; break; end
      vis[upc_o] = 1'b1;
      if (upc_o == 7'o001) c1++;
      if (rf_we && gn < 4) begin gi[gn] = rf_waddr; gd[gn] = rf_wdata; gn++; end
      if (end_o) ends++;
      pend = end_o;
    end
    chk({tg, " R9 instruction completes"}, fin, 1);
    chk({tg, " R2 fetch address"}, last_fetch, fexp);
    chk({tg, " R2 pc after instruction"}, pc_o, mpc);
    chk({tg, " R9 read count"}, nreads, ereads);
    chk({tg, " R10 end count"}, ends, eends);
    chk({tg, " R11 write count"}, gn, en);
    for (int k = 0; k < 2; k++) if (k < en && k < gn) begin
      chk({tg, " R11 write index"}, gi[k], ei[k]);
      chk({tg, " R11 write data"}, gd[k], ed[k]);
    end
    if (fix_lat > 0) chk({tg, " R9 fetch wait length"}, c1, fix_lat + 1);
    if (op == 5'd1) begin
      chk({tg, " R3 dispatch target visited"}, vis[tgt], 1);
      if (md == 3'b011) chk({tg, " R5 octal 170 skipped"}, vis[7'o170], 0);
      if (md == 3'b010) chk({tg, " R6 octal 170 visited"}, vis[7'o170], 1);
      if (md == 3'b000) chk({tg, " R7 jump to octal 172"}, vis[7'o172], 1);
      if (md == 3'b001 || md[2]) chk({tg, " R8 no register write"}, gn, 0);
    end else if (op == 5'd2) begin
      chk({tg, " R4 offset word visited"}, vis[7'o041], n);
    end else begin
      chk({tg, " R3 unknown opcode stays in fetch"}, |vis[127:4], 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 16; i++) mr[i] = 16'(i) << 8;
    mpc = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset upc", upc_o, 0);
    chk("R1 reset pc", pc_o, 0);
    chk("R1 reset read", mem_rd, 0);
    chk("R1 reset end", end_o, 0);
    chk("R1 reset write", rf_we, 0);
    rst_n = 1'b1;
    run_instr({5'd1, 3'b000, 4'd3, 4'd5}, 1'b0, "R1 R7 direct add of reset values");
    fix_lat = 6;
    run_instr({5'd1, 3'b011, 4'd2, 4'd6}, 1'b0, "R5 autoincrement slow memory");
    fix_lat = 1;
    run_instr({5'd1, 3'b010, 4'd4, 4'd4}, 1'b0, "R6 indirect same register");
    run_instr({5'd1, 3'b011, 4'd7, 4'd7}, 1'b0, "R5 autoincrement same register");
    fix_lat = 0;
    run_instr({5'd1, 3'b001, 4'd1, 4'd2}, 1'b0, "R8 mode 001");
    run_instr({5'd1, 3'b101, 4'd1, 4'd2}, 1'b0, "R8 mode 101");
    run_instr({5'd2, 3'b000, 8'h10}, 1'b0, "R4 branch not taken");
    run_instr({5'd2, 3'b000, 8'hF0}, 1'b1, "R4 branch taken backward");
    run_instr({5'd7, 3'b011, 4'd1, 4'd2}, 1'b1, "R3 unknown opcode");
    run_instr({5'd0, 3'b000, 4'd0, 4'd0}, 1'b0, "R3 opcode zero");
    for (int t = 0; t < 80; t++) begin
      int r = int'($urandom % 100);
      int k = int'($urandom % 8);
      logic [2:0] md = (k < 3) ? 3'b011 : (k < 5) ? 3'b010 : (k < 7) ? 3'b000 : 3'($urandom);
      logic [7:0] lo = 8'($urandom);
      if (r < 55) run_instr({5'd1, md, lo}, 1'($urandom), "R11 random add");
      else if (r < 80) run_instr({5'd2, 3'($urandom), lo}, 1'($urandom), "R4 random branch");
      else run_instr({5'd3 + 5'($urandom % 29), 3'($urandom), lo}, 1'($urandom), "R3 random opcode");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule